// File: doc/BRIEF.md
# Programmable-Logic Configuration Fuse Store

This block keeps the complete configuration map of a small programmable logic device: 2706 single-bit fuses that hold the product-term array, eight per-cell polarity bits, eight per-cell input/output selection bits, two global mode bits and a 64-bit user signature. A loader fills the map one fuse at a time through an addressed write port. A bulk erase first returns every fuse to 1 and then leaves the map unprotected. A single-bit addressed read port lets test equipment verify the contents.

A security bit protects the pattern. Once it is set, any read of a functional fuse is refused, but the user signature field stays readable. Only a completed bulk erase clears the security bit. A 16-bit checksum of the whole map, signature included, is kept current after every change. The architecture fields are decoded continuously and drive the macrocell configuration of the surrounding logic, including a two-bit summary of the global operating mode.

Top module: `fuse_cfg_store`

## Requirements
- R1: After reset every fuse is 0, `checksum` is 0, `sec_on` is 0, `busy` is 0 and `mode` is 0.
- R2: A `wr_en` sampled at an edge while `busy` and `erase_req` are both low stores `wr_bit` into fuse `wr_addr`. A write to an address of 2706 or above changes nothing.
- R3: An `erase_req` sampled while idle raises `busy` for exactly 339 cycles, one cycle for each 8-fuse group. Afterwards every fuse reads 1. Writes presented while `busy` is high are dropped.
- R4: A `rd_en` at an edge gives `rd_valid`=1 after that edge, with `rd_bit` equal to the fuse at `rd_addr`. An address of 2706 or above returns 0 with `rd_refused`=0.
- R5: A `lock_req` sampled while idle sets `sec_on`. While `sec_on` is 1, a read of an in-range address outside 2568..2631 returns `rd_bit`=0 with `rd_refused`=1. Writes do not clear `sec_on`. Only the last cycle of an erase clears it.
- R6: Reads of addresses 2568 to 2631, the user signature with byte 0 in the lowest addresses, are never refused.
- R7: `checksum` is the 16-bit wrapping sum of the map taken as 8-bit groups. Group g holds fuses 8g (bit 0) to 8g+7 (bit 7), and the top group is padded with zeros above fuse 2705. The sum is current one edge after each change and covers the signature.
- R8: `cell_xor[i]` equals fuse 2560+i, `cell_ac1[i]` equals fuse 2632+i, `glob_syn` equals fuse 2704 and `glob_ac0` equals fuse 2705.
- R9: `mode` decodes `{glob_syn,glob_ac0}` as follows: 2'b10 gives 1 (simple), 2'b11 gives 2 (complex), 2'b01 gives 3 (registered) and 2'b00 gives 0 (not a legal mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| erase_req | input | 1 | Start a bulk erase |
| busy | output | 1 | Erase in progress |
| wr_en | input | 1 | Write one fuse |
| wr_addr | input | 12 | Write fuse address |
| wr_bit | input | 1 | Write value |
| lock_req | input | 1 | Set the security bit |
| sec_on | output | 1 | Security bit state |
| rd_en | input | 1 | Read one fuse |
| rd_addr | input | 12 | Read fuse address |
| rd_valid | output | 1 | Read result present |
| rd_bit | output | 1 | Read result |
| rd_refused | output | 1 | Read blocked by security |
| checksum | output | 16 | Running map checksum |
| cell_xor | output | 8 | Per-cell polarity bits |
| cell_ac1 | output | 8 | Per-cell I/O selection bits |
| glob_syn | output | 1 | Global mode bit at 2704 |
| glob_ac0 | output | 1 | Global mode bit at 2705 |
| mode | output | 2 | Decoded global mode |

## Verification
The assertions assume that `erase_req` and `lock_req` are single-cycle pulses. They also assume that a read and a write never target the same group in the same cycle, because a read in that cycle returns the value from before the edge. The bench drives every request for exactly one clock and changes inputs only on falling edges. It issues reads only after the write they depend on has completed. The one write made during an erase targets a group that the erase has already passed, so the bench can see that the write was dropped.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

  typedef enum logic [1:0] {
    MODE_NONE    = 2'd0,
    MODE_SIMPLE  = 2'd1,
    MODE_COMPLEX = 2'd2,
    MODE_REG     = 2'd3
  } mode_e;

endpackage

// File: rtl/fuse_erase_seq.sv
module fuse_erase_seq #(
  parameter int NGRP = 339,
  parameter int GIW  = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  output logic           busy,
  output logic           step_en,
  output logic [GIW-1:0] step_idx,
  output logic           done
);

  localparam logic [GIW-1:0] LAST = GIW'(NGRP - 1);

  logic           busy_q, busy_d;
  logic [GIW-1:0] idx_q, idx_d;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    if (busy_q) begin
      idx_d = idx_q + 1'b1;
      if (idx_q == LAST) busy_d = 1'b0;
    end else if (start) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  assign busy     = busy_q;
  assign step_en  = busy_q;
  assign step_idx = idx_q;
  assign done     = busy_q && (idx_q == LAST);

  // R3: an erase begins only on request
  a_r3_start_by_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(start));

  // R3: the walker never leaves the map
  a_r3_idx_in_map: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> idx_q <= LAST);

endmodule

// File: rtl/fuse_bank.sv
module fuse_bank #(
  parameter int NGRP     = 339,
  parameter int GW       = 8,
  parameter int GIW      = 9,
  parameter int NCELL    = 8,
  parameter int XOR_BASE = 2560,
  parameter int AC1_BASE = 2632,
  parameter int SYN_ADR  = 2704,
  parameter int AC0_ADR  = 2705
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_en,
  input  logic [GIW-1:0]   mod_idx,
  input  logic [GW-1:0]    mod_val,
  output logic [GW-1:0]    old_val,
  input  logic [GIW-1:0]   rd_idx,
  output logic [GW-1:0]    rd_grp,
  output logic [NCELL-1:0] arch_xor,
  output logic [NCELL-1:0] arch_ac1,
  output logic             arch_syn,
  output logic             arch_ac0
);

  logic [GW-1:0] mem [NGRP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NGRP; g++) mem[g] <= '0;
    end else if (mod_en) begin
      mem[mod_idx] <= mod_val;
    end
  end

  assign old_val = mem[mod_idx];
  assign rd_grp  = mem[rd_idx];

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    assign arch_xor[i] = mem[(XOR_BASE + i) / GW][(XOR_BASE + i) % GW];
    assign arch_ac1[i] = mem[(AC1_BASE + i) / GW][(AC1_BASE + i) % GW];
  end
  assign arch_syn = mem[SYN_ADR / GW][SYN_ADR % GW];
  assign arch_ac0 = mem[AC0_ADR / GW][AC0_ADR % GW];

  // R2: updates only land inside the map
  a_r2_mod_in_map: assert property (@(posedge clk) disable iff (!rst_n)
    mod_en |-> mod_idx < GIW'(NGRP));

endmodule

// File: rtl/fuse_cksum.sv
module fuse_cksum #(
  parameter int GW  = 8,
  parameter int CKW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mod_en,
  input  logic [GW-1:0]  old_val,
  input  logic [GW-1:0]  new_val,
  output logic [CKW-1:0] sum
);

  logic [CKW-1:0] sum_q, sum_d;

  always_comb begin
    sum_d = sum_q;
    if (mod_en) sum_d = sum_q + CKW'(new_val) - CKW'(old_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= sum_d;
  end

  assign sum = sum_q;

  // R7: the sum moves only when a group changes
  a_r7_sum_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |=> $stable(sum_q));

endmodule

// File: rtl/fuse_mode_dec.sv
module fuse_mode_dec
  import fuse_pkg::*;
(
  input  logic  syn,
  input  logic  ac0,
  output mode_e mode
);

  always_comb begin
    unique case ({syn, ac0})
      2'b10:   mode = MODE_SIMPLE;
      2'b11:   mode = MODE_COMPLEX;
      2'b01:   mode = MODE_REG;
      default: mode = MODE_NONE;
    endcase
  end

endmodule

// File: rtl/fuse_cfg_store.sv
module fuse_cfg_store
  import fuse_pkg::*;
#(
  parameter int N_FUSE   = 2706,
  parameter int GW       = 8,
  parameter int AW       = 12,
  parameter int CKW      = 16,
  parameter int NCELL    = 8,
  parameter int XOR_BASE = 2560,
  parameter int SIG_LO   = 2568,
  parameter int SIG_HI   = 2631,
  parameter int AC1_BASE = 2632,
  parameter int SYN_ADR  = 2704,
  parameter int AC0_ADR  = 2705
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             erase_req,
  output logic             busy,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic             wr_bit,
  input  logic             lock_req,
  output logic             sec_on,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic             rd_valid,
  output logic             rd_bit,
  output logic             rd_refused,
  output logic [CKW-1:0]   checksum,
  output logic [NCELL-1:0] cell_xor,
  output logic [NCELL-1:0] cell_ac1,
  output logic             glob_syn,
  output logic             glob_ac0,
  output logic [1:0]       mode
);

  localparam int NGRP = (N_FUSE + GW - 1) / GW;
  localparam int BW   = $clog2(GW);
  localparam int GIW  = AW - BW;
  localparam logic [AW-1:0] ADR_LIM = AW'(N_FUSE);
  localparam logic [AW-1:0] SIG_A0  = AW'(SIG_LO);
  localparam logic [AW-1:0] SIG_A1  = AW'(SIG_HI);

  function automatic logic [GW-1:0] grp_mask(input logic [GIW-1:0] g);
    logic [GW-1:0] m;
    for (int b = 0; b < GW; b++) m[b] = ((int'(g) * GW + b) < N_FUSE);
    return m;
  endfunction

  // erase walker
  logic           step_en, erase_done;
  logic [GIW-1:0] step_idx;

  fuse_erase_seq #(.NGRP(NGRP), .GIW(GIW)) u_erase (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (erase_req),
    .busy     (busy),
    .step_en  (step_en),
    .step_idx (step_idx),
    .done     (erase_done)
  );

  // group update selection: erase step or accepted write
  logic           wr_ok, mod_en;
  logic [GIW-1:0] mod_idx, rd_idx;
  logic [GW-1:0]  mod_val, old_val, rd_grp;
  logic           rd_in_map;

  assign wr_ok = wr_en && !busy && !erase_req && (wr_addr < ADR_LIM);

  always_comb begin
    mod_en  = 1'b0;
    mod_idx = wr_addr[AW-1:BW];
    mod_val = old_val;
    if (step_en) begin
      mod_en  = 1'b1;
      mod_idx = step_idx;
      mod_val = grp_mask(step_idx);
    end else if (wr_ok) begin
      mod_en = 1'b1;
      mod_val[wr_addr[BW-1:0]] = wr_bit;
    end
  end

  assign rd_in_map = rd_addr < ADR_LIM;
  assign rd_idx    = rd_in_map ? rd_addr[AW-1:BW] : '0;

  fuse_bank #(
    .NGRP(NGRP), .GW(GW), .GIW(GIW), .NCELL(NCELL),
    .XOR_BASE(XOR_BASE), .AC1_BASE(AC1_BASE),
    .SYN_ADR(SYN_ADR), .AC0_ADR(AC0_ADR)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .mod_en   (mod_en),
    .mod_idx  (mod_idx),
    .mod_val  (mod_val),
    .old_val  (old_val),
    .rd_idx   (rd_idx),
    .rd_grp   (rd_grp),
    .arch_xor (cell_xor),
    .arch_ac1 (cell_ac1),
    .arch_syn (glob_syn),
    .arch_ac0 (glob_ac0)
  );

  fuse_cksum #(.GW(GW), .CKW(CKW)) u_sum (
    .clk     (clk),
    .rst_n   (rst_n),
    .mod_en  (mod_en),
    .old_val (old_val),
    .new_val (mod_val),
    .sum     (checksum)
  );

  mode_e mode_w;
  fuse_mode_dec u_mode (
    .syn  (glob_syn),
    .ac0  (glob_ac0),
    .mode (mode_w)
  );
  assign mode = mode_w;

  // security bit
  logic sec_q, sec_d;
  always_comb begin
    sec_d = sec_q;
    if (erase_done)             sec_d = 1'b0;
    else if (lock_req && !busy) sec_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sec_q <= 1'b0;
    else        sec_q <= sec_d;
  end
  assign sec_on = sec_q;

  // read port
  logic in_sig, refuse_w;
  logic vld_q, bit_q, ref_q, bit_d, ref_d;

  assign in_sig   = (rd_addr >= SIG_A0) && (rd_addr <= SIG_A1);
  assign refuse_w = rd_in_map && sec_q && !in_sig;

  always_comb begin
    bit_d = bit_q;
    ref_d = ref_q;
    if (rd_en) begin
      ref_d = refuse_w;
      bit_d = (rd_in_map && !refuse_w) ? rd_grp[rd_addr[BW-1:0]] : 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      bit_q <= 1'b0;
      ref_q <= 1'b0;
    end else begin
      vld_q <= rd_en;
      bit_q <= bit_d;
      ref_q <= ref_d;
    end
  end

  assign rd_valid   = vld_q;
  assign rd_bit     = bit_q;
  assign rd_refused = ref_q;

  // R5: a refused read never leaks a fuse value
  a_r5_refused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_refused) |-> !rd_bit);

  // R5: security drops only at the end of an erase
  a_r5_sec_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sec_q) |-> $past(busy) && !busy);

  // R6: the signature field is always readable
  a_r6_sig_open: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr >= SIG_A0 && rd_addr <= SIG_A1) |=> !rd_refused);

  // R8: a finished erase leaves every architecture bit at 1
  a_r8_erased_arch: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (&cell_xor) && (&cell_ac1) && glob_syn && glob_ac0);

  // R9: an erased map decodes as the complex mode
  a_r9_erased_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> mode == 2'd2);

endmodule

// File: tb/sim_fuse_cfg_store.sv
module sim_fuse_cfg_store;

  localparam int NF = 2706;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        erase_req, wr_en, wr_bit, lock_req, rd_en;
  logic [11:0] wr_addr, rd_addr;
  logic        busy, sec_on, rd_valid, rd_bit, rd_refused, glob_syn, glob_ac0;
  logic [15:0] checksum;
  logic [7:0]  cell_xor, cell_ac1;
  logic [1:0]  mode;

  always #5 clk = ~clk;

  fuse_cfg_store u0 (
    .clk(clk), .rst_n(rst_n), .erase_req(erase_req), .busy(busy),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_bit(wr_bit),
    .lock_req(lock_req), .sec_on(sec_on),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_bit(rd_bit), .rd_refused(rd_refused), .checksum(checksum),
    .cell_xor(cell_xor), .cell_ac1(cell_ac1),
    .glob_syn(glob_syn), .glob_ac0(glob_ac0), .mode(mode)
  );

  int checks = 0;
  int errors = 0;
  logic mdl [NF];

  // vector: {op(2), value(1), addr(12)}; op 1 = write, op 2 = read with expected bit
  localparam int NV = 13;
  localparam logic [14:0] TBL [NV] = '{
    {2'd1, 1'b1, 12'd7},    {2'd1, 1'b1, 12'd2560}, {2'd1, 1'b1, 12'd2705},
    {2'd2, 1'b1, 12'd7},    {2'd2, 1'b0, 12'd8},    {2'd1, 1'b1, 12'd2704},
    {2'd2, 1'b1, 12'd2560}, {2'd1, 1'b1, 12'd2600}, {2'd2, 1'b1, 12'd2600},
    {2'd1, 1'b1, 12'd4000}, {2'd2, 1'b0, 12'd4000}, {2'd1, 1'b0, 12'd7},
    {2'd2, 1'b0, 12'd7}
  };

  function automatic logic [15:0] model_sum();
    logic [15:0] s = 16'd0;
    for (int i = 0; i < NF; i++) if (mdl[i]) s = s + (16'd1 << (i % 8));
    return s;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic b);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_bit = b;
    @(negedge clk);
    wr_en = 1'b0;
    if (a < NF) mdl[a] = b;
  endtask

  task automatic do_read(input logic [11:0] a, input logic eb, input logic er, input string req);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check({req, " valid"}, {31'd0, rd_valid}, 32'd1);
    check({req, " bit"}, {31'd0, rd_bit}, {31'd0, eb});
    check({req, " refused"}, {31'd0, rd_refused}, {31'd0, er});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R3 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cnt;
    rst_n = 1'b0; erase_req = 1'b0; wr_en = 1'b0; wr_bit = 1'b0;
    lock_req = 1'b0; rd_en = 1'b0; wr_addr = '0; rd_addr = '0;
    for (int i = 0; i < NF; i++) mdl[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 checksum", {16'd0, checksum}, 32'd0);
    check("R1 sec_on", {31'd0, sec_on}, 32'd0);
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 mode", {30'd0, mode}, 32'd0);

    // R2 R4 R8 vector walk
    for (int v = 0; v < NV; v++) begin
      if (TBL[v][14:13] == 2'd1) do_write(TBL[v][11:0], TBL[v][12]);
      else do_read(TBL[v][11:0], TBL[v][12], 1'b0, "R2 R4 table read");
    end

    // R7 checksum includes signature
    check("R7 checksum after writes", {16'd0, checksum}, {16'd0, model_sum()});
    do_write(12'd2631, 1'b1);
    check("R7 signature top bit moves checksum", {16'd0, checksum}, {16'd0, model_sum()});

    // R8 R9 decode
    check("R8 cell_xor", {24'd0, cell_xor}, 32'h01);
    check("R8 cell_ac1", {24'd0, cell_ac1}, 32'h00);
    check("R9 complex", {30'd0, mode}, 32'd2);
    do_write(12'd2704, 1'b0);
    check("R9 registered", {30'd0, mode}, 32'd3);
    do_write(12'd2705, 1'b0); do_write(12'd2704, 1'b1);
    check("R9 simple", {30'd0, mode}, 32'd1);
    do_write(12'd2639, 1'b1);
    check("R8 cell_ac1 top", {24'd0, cell_ac1}, 32'h80);
    do_write(12'd2704, 1'b0);
    check("R9 none", {30'd0, mode}, 32'd0);

    // R5 R6 security
    do_write(12'd7, 1'b1);
    do_write(12'd2568, 1'b1);
    @(negedge clk); lock_req = 1'b1; @(negedge clk); lock_req = 1'b0;
    check("R5 sec set", {31'd0, sec_on}, 32'd1);
    do_read(12'd7, 1'b0, 1'b1, "R5 refused functional");
    do_read(12'd2560, 1'b0, 1'b1, "R5 refused xor field");
    do_read(12'd2568, 1'b1, 1'b0, "R6 signature low");
    do_read(12'd2631, 1'b1, 1'b0, "R6 signature high");
    do_read(12'd2600, 1'b1, 1'b0, "R6 signature mid");
    do_read(12'd2632, 1'b0, 1'b1, "R5 refused ac1 field");
    do_write(12'd100, 1'b1);
    check("R5 write keeps lock", {31'd0, sec_on}, 32'd1);
    check("R7 checksum while locked", {16'd0, checksum}, {16'd0, model_sum()});

    // R3 erase
    @(negedge clk); erase_req = 1'b1; @(negedge clk); erase_req = 1'b0;
    cnt = 0;
    while (busy) begin
      cnt++;
      if (cnt == 200) begin
        wr_en = 1'b1; wr_addr = 12'd0; wr_bit = 1'b0;
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
    end
    wr_en = 1'b0;
    for (int i = 0; i < NF; i++) mdl[i] = 1'b1;
    check("R3 busy length", cnt, 32'd339);
    check("R5 sec cleared by erase", {31'd0, sec_on}, 32'd0);
    do_read(12'd0, 1'b1, 1'b0, "R3 write during erase dropped");
    do_read(12'd1234, 1'b1, 1'b0, "R3 erased fuse");
    do_read(12'd2705, 1'b1, 1'b0, "R3 last fuse");
    check("R7 erased checksum", {16'd0, checksum}, {16'd0, model_sum()});
    check("R9 erased mode", {30'd0, mode}, 32'd2);
    do_read(12'd2706, 1'b0, 1'b0, "R4 first out of map");
    do_write(12'd2706, 1'b0);
    check("R2 out of map write", {16'd0, checksum}, {16'd0, model_sum()});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule